// File: doc/BRIEF.md
# Packed SIMD Complex Multiplier

This block is a two-stage pipelined multiply unit for signal-processing datapaths. Each 32-bit operand carries two signed 16-bit halves. The complex modes read these halves as one complex number, with the real part in the upper half and the imaginary part in the lower half. A 3-bit opcode selects the mode. There are two complex modes: one keeps full precision and the other rounds and packs its result. There is also a dual 16x16 mode, a quad 8x8 mode and a quad 8x8 mode that sums its four products.

The unit can accept a new operation on every clock cycle. A valid strobe travels beside the data. The 64-bit result and its valid flag appear two cycles after the operation is accepted. When no valid operation finishes in a cycle, the result register keeps its last value.

Top module: `cplx_simd_mul`

## Requirements
- R1: While reset is held and after it is released, validOut is 0 and result is 0 until the first accepted operation finishes.
- R2: An operation accepted with validIn=1 at a rising edge drives validOut=1 after exactly the second rising edge that follows. A new operation can be accepted on every cycle, so a back-to-back stream comes out back to back.
- R3: Opcode 0 (full complex) returns result[63:32] = ar*br - ai*bi and result[31:0] = ar*bi + ai*br. Here ar=a[31:16], ai=a[15:0], br=b[31:16] and bi=b[15:0], all signed. Each sum is kept to its low 32 bits, so the single out-of-range case wraps.
- R4: Opcode 1 (rounded complex) takes each exact sum, adds 0x8000, shifts it arithmetically right by 16 and saturates it to -32768..32767. The real part goes to result[31:16], the imaginary part to result[15:0], and result[63:32] is 0.
- R5: Opcode 2 (dual) returns result[63:32] = a[31:16]*b[31:16] and result[31:0] = a[15:0]*b[15:0], both signed.
- R6: Opcode 3 (quad) places the signed product of byte lane i of a and byte lane i of b, for i=0..3, in result[16*i+15:16*i].
- R7: Opcode 4 (quad sum) returns the sum of the four signed byte-lane products, sign-extended to 64 bits.
- R8: Opcodes 5, 6 and 7 still produce validOut, with a result of 0.
- R9: When no valid operation finishes in a cycle, result keeps its previous value and validOut is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Operation strobe |
| opIn | input | 3 | Mode select |
| aIn | input | 32 | Operand A |
| bIn | input | 32 | Operand B |
| validOut | output | 1 | Result strobe, two cycles after validIn |
| result | output | 64 | Formatted product |

## Verification
The bench builds the block with its default DATA_W of 32, so each operand has 16-bit halves and 8-bit lanes. At that width, operands made only of -32768 halves reach both the wrap of the full-precision imaginary sum and the positive saturation of the rounded mode. The same width lets lanes of -128 push the quad sum to +65536, past the range of 17 signed bits. The random stream mixes every opcode, including the unused ones, with idle cycles, so hold behaviour and back-to-back issue are both exercised.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_CFULL  = 3'd0;
  localparam logic [OP_W-1:0] OP_CRND   = 3'd1;
  localparam logic [OP_W-1:0] OP_DUAL16 = 3'd2;
  localparam logic [OP_W-1:0] OP_QUAD8  = 3'd3;
  localparam logic [OP_W-1:0] OP_QSUM8  = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic            ld1;  // capture partial products
    logic            ld2;  // capture formatted result
    logic [OP_W-1:0] op2;  // opcode aligned to stage 2
  } cmulStrobeT;
endpackage

// File: rtl/cmul_ctrl.sv
module cmul_ctrl
  import cmul_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            validIn,
  input  logic [OP_W-1:0] opIn,
  output cmulStrobeT      strb,
  output logic            validOut
);
  logic            v1Q, v2Q;
  logic [OP_W-1:0] op1Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1Q  <= 1'b0;
      v2Q  <= 1'b0;
      op1Q <= '0;
    end else begin
      v1Q <= validIn;
      v2Q <= v1Q;
      if (validIn) op1Q <= opIn;
    end
  end

  always_comb begin
    strb.ld1 = validIn;
    strb.ld2 = v1Q;
    strb.op2 = op1Q;
  end

  assign validOut = v2Q;
endmodule

// File: rtl/cmul_datapath.sv
module cmul_datapath
  import cmul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  cmulStrobeT          strb,
  input  logic [DATA_W-1:0]   aIn,
  input  logic [DATA_W-1:0]   bIn,
  output logic [2*DATA_W-1:0] result
);
  localparam int HW    = DATA_W / 2;
  localparam int LW    = DATA_W / 4;
  localparam int NLANE = 4;
  localparam int RW    = 2 * DATA_W;
  localparam int PW    = 2 * LW;
  localparam int SW    = PW + 2;
  localparam logic signed [HW:0] RMAX = {2'b00, {(HW-1){1'b1}}};
  localparam logic signed [HW:0] RMIN = {2'b11, {(HW-1){1'b0}}};
  localparam logic signed [DATA_W:0] RBIAS = (DATA_W+1)'(1) <<< (HW-1);

  logic signed [HW-1:0] ar, ai, br, bi;
  assign ar = aIn[DATA_W-1:HW];
  assign ai = aIn[HW-1:0];
  assign br = bIn[DATA_W-1:HW];
  assign bi = bIn[HW-1:0];

  // Stage 1: half-word cross products and byte-lane products
  logic signed [DATA_W-1:0] pRRQ, pIIQ, pRIQ, pIRQ;
  logic signed [PW-1:0]     pQQ [NLANE];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pRRQ <= '0;
      pIIQ <= '0;
      pRIQ <= '0;
      pIRQ <= '0;
    end else if (strb.ld1) begin
      pRRQ <= ar * br;
      pIIQ <= ai * bi;
      pRIQ <= ar * bi;
      pIRQ <= ai * br;
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic signed [LW-1:0] aL, bL;
    assign aL = aIn[LW*g +: LW];
    assign bL = bIn[LW*g +: LW];
    always_ff @(posedge clk) begin
      if (!rstN)         pQQ[g] <= '0;
      else if (strb.ld1) pQQ[g] <= aL * bL;
    end
  end

  // Stage 2: combine and format
  logic signed [DATA_W:0] reW, imW;
  logic signed [SW-1:0]   qSum;
  logic [HW-1:0]          reR, imR;
  logic [RW-1:0]          resD, resQ;
  logic [RW-1:0]          quadCat;

  function automatic logic [HW-1:0] satRound(input logic signed [DATA_W:0] v);
    logic signed [DATA_W:0] t;
    logic signed [HW:0]     sh;
    t  = v + RBIAS;
    sh = t[DATA_W:HW];
    if (sh > RMAX)      return RMAX[HW-1:0];
    else if (sh < RMIN) return RMIN[HW-1:0];
    else                return sh[HW-1:0];
  endfunction

  always_comb begin
    reW = (DATA_W+1)'(pRRQ) - (DATA_W+1)'(pIIQ);
    imW = (DATA_W+1)'(pRIQ) + (DATA_W+1)'(pIRQ);
    reR = satRound(reW);
    imR = satRound(imW);
  end

  always_comb begin
    qSum    = '0;
    quadCat = '0;
    for (int i = 0; i < NLANE; i++) begin
      qSum = qSum + SW'(pQQ[i]);
      quadCat[PW*i +: PW] = pQQ[i];
    end
  end

  always_comb begin
    case (strb.op2)
      OP_CFULL:  resD = {reW[DATA_W-1:0], imW[DATA_W-1:0]};
      OP_CRND:   resD = {{DATA_W{1'b0}}, reR, imR};
      OP_DUAL16: resD = {pRRQ, pIIQ};
      OP_QUAD8:  resD = quadCat;
      OP_QSUM8:  resD = RW'(qSum);
      default:   resD = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         resQ <= '0;
    else if (strb.ld2) resQ <= resD;
  end

  assign result = resQ;
endmodule

// File: rtl/cplx_simd_mul.sv
module cplx_simd_mul
  import cmul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                validIn,
  input  logic [2:0]          opIn,
  input  logic [DATA_W-1:0]   aIn,
  input  logic [DATA_W-1:0]   bIn,
  output logic                validOut,
  output logic [2*DATA_W-1:0] result
);
  cmulStrobeT strb;

  cmul_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opIn(opIn),
    .strb(strb), .validOut(validOut)
  );

  cmul_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .aIn(aIn), .bIn(bIn),
    .result(result)
  );
endmodule

// File: rtl/cmul_checker.sv
module cmul_checker #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                validIn,
  input logic [2:0]          opIn,
  input logic                validOut,
  input logic [2*DATA_W-1:0] result
);
  localparam int RW = 2 * DATA_W;
  localparam int SB = DATA_W / 2 + 2;  // sum width in bits

  logic [1:0] age;  // cycles since reset, saturating
  always_ff @(posedge clk) begin
    if (!rstN)         age <= 2'd0;
    else if (age != 3) age <= age + 2'd1;
  end

  // R1
  p_reset_idle_r1: assert property (@(posedge clk) !rstN |=> (!validOut && result == '0));

  // R2
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2) |-> (validOut == $past(validIn, 2)));

  // R9
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd3 && !validOut) |-> $stable(result));

  // R4
  p_rnd_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2 && validOut && $past(opIn, 2) == 3'd1) |-> (result[RW-1:DATA_W] == '0));

  // R7
  p_sum_sext_r7: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2 && validOut && $past(opIn, 2) == 3'd4)
      |-> (result[RW-1:SB-1] == '0 || result[RW-1:SB-1] == '1));

  // R8
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2 && validOut && $past(opIn, 2) > 3'd4) |-> (result == '0));
endmodule

bind cplx_simd_mul cmul_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .validIn(validIn), .opIn(opIn),
  .validOut(validOut), .result(result)
);

// File: tb/cplx_simd_mul_bench.sv
module cplx_simd_mul_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [2:0]  opIn = '0;
  logic [31:0] aIn = '0, bIn = '0;
  logic        validOut;
  logic [63:0] result;

  int nCmp = 0, nBad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  cplx_simd_mul u_cplx_simd_mul (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opIn(opIn),
    .aIn(aIn), .bIn(bIn), .validOut(validOut), .result(result)
  );

  function automatic logic [63:0] expFn(logic [31:0] a, logic [31:0] b, logic [2:0] op);
    longint ar, ai, br, bi, re, im, tr, ti, s;
    logic [63:0] r;
    ar = longint'($signed(a[31:16])); ai = longint'($signed(a[15:0]));
    br = longint'($signed(b[31:16])); bi = longint'($signed(b[15:0]));
    re = ar*br - ai*bi;
    im = ar*bi + ai*br;
    r = '0;
    case (op)
      3'd0: r = {re[31:0], im[31:0]};
      3'd1: begin
        tr = (re + 32768) >>> 16; ti = (im + 32768) >>> 16;
        if (tr > 32767) tr = 32767; if (tr < -32768) tr = -32768;
        if (ti > 32767) ti = 32767; if (ti < -32768) ti = -32768;
        r = {32'd0, tr[15:0], ti[15:0]};
      end
      3'd2: begin
        tr = ar*br; ti = ai*bi;
        r = {tr[31:0], ti[31:0]};
      end
      3'd3, 3'd4: begin
        s = 0;
        for (int i = 0; i < 4; i++) begin
          tr = longint'($signed(a[8*i +: 8])) * longint'($signed(b[8*i +: 8]));
          r[16*i +: 16] = tr[15:0];
          s += tr;
        end
        if (op == 3'd4) r = s;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected pipeline
  logic        h1V = 0, h2V = 0;
  logic [2:0]  h1Op = 0, h2Op = 0;
  logic [63:0] h1R = 0, h2R = 0, lastR = 0;

  function automatic string opReq(logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic step(bit v, logic [2:0] op, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    chk(h2V ? "R2 valid" : "R9 idle valid", {63'd0, validOut}, {63'd0, h2V});
    if (h2V) begin
      chk(opReq(h2Op), result, h2R);
      lastR = h2R;
    end else begin
      chk("R9 hold", result, lastR);
    end
    h2V = h1V; h2Op = h1Op; h2R = h1R;
    h1V = v; h1Op = op; h1R = expFn(a, b, op);
    validIn = v; opIn = op; aIn = a; bIn = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {63'd0, validOut}, 64'd0);
    chk("R1 reset result", result, 64'd0);
    rstN = 1'b1;
    chk("R1 after release", result, 64'd0);
    void'($urandom(32'h5eed_c0de));
    // directed corners
    step(1, 3'd1, 32'h8000_8000, 32'h8000_8000); // R4 positive saturation
    step(1, 3'd0, 32'h8000_8000, 32'h8000_8000); // R3 imaginary wrap
    step(1, 3'd4, 32'h8080_8080, 32'h8080_8080); // R7 sum 65536
    step(1, 3'd3, 32'h80FF_7F01, 32'h807F_7FFF); // R6 lane signs
    step(1, 3'd2, 32'h8000_7FFF, 32'h7FFF_8000); // R5
    step(1, 3'd6, 32'h1234_5678, 32'h9ABC_DEF0); // R8
    step(0, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R9 idle
    step(0, 3'd1, 32'h0, 32'h0);
    step(1, 3'd1, 32'h0001_FFFF, 32'h7FFF_8001); // R4 rounding
    step(1, 3'd1, 32'h8000_7FFF, 32'h7FFF_7FFF); // R4
    for (int n = 0; n < 3000; n++)
      step(($urandom % 5) != 0, 3'($urandom_range(0, 7)), $urandom, $urandom);
    step(0, 3'd0, 0, 0);
    step(0, 3'd0, 0, 0);
    step(0, 3'd0, 0, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule